// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and decides per branch which one to trust. The first component hashes a global outcome history with the branch address to pick a 2-bit counter. The second component picks a 2-bit counter from the branch address alone. A third table of 2-bit selector counters, also indexed by address bits, learns which component has been more accurate for the branches that map to each entry.

The fetch side presents an address and gets the final direction and both component directions in the same cycle. When the branch resolves, the back end sends the address, the real outcome and the two component directions that were reported at lookup time. The block then trains both component tables with the outcome. It moves the selector only when exactly one component was right. It also shifts the outcome into the global history.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every component counter holds 1 (weakly not-taken), every selector counter holds 2, and the global history is zero. So any lookup then reports predGshare=0, predBimodal=0 and predTaken=0.
- R2: The hashed component reads the counter at index (history XOR lookupPc[GS_IDX_W-1:0]). Its prediction is that counter's upper bit (1 = taken).
- R3: The address-only component reads the counter at index lookupPc[BIM_IDX_W-1:0]. Its prediction is that counter's upper bit.
- R4: On each accepted update, both component counters addressed by updPc and the current history move one step toward updTaken, saturating at 0 and 3. This holds whichever component was selected.
- R5: On each accepted update, the history shifts left by one and updTaken enters bit 0.
- R6: The selector entry at lookupPc[CH_IDX_W-1:0] chooses the hashed component when its upper bit is 1 (values 2, 3) and the address-only component when it is 0 (values 0, 1).
- R7: If updGsharePred equals updTaken and updBimodalPred does not, the selector entry at updPc increments, saturating at 3.
- R8: If updBimodalPred equals updTaken and updGsharePred does not, the selector entry decrements, saturating at 0.
- R9: If both component predictions were right, or both were wrong, the selector entry is unchanged.
- R10: While updValid is 0, the other update inputs have no effect on any later prediction.
- R11: Lookup is combinational on stored state. An update becomes visible only after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookupPc | input | ADDR_W | Address of the branch being predicted |
| predTaken | output | 1 | Final selected direction |
| predGshare | output | 1 | Hashed-history component direction |
| predBimodal | output | 1 | Address-only component direction |
| updValid | input | 1 | Resolution strobe |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome |
| updGsharePred | input | 1 | Hashed component direction given at lookup |
| updBimodalPred | input | 1 | Address-only component direction given at lookup |

## Verification
A wrong selector value only shows at the ports for an address where the two component directions disagree. There, predTaken follows the wrong component from the cycle after the faulty update. A bad history bit moves the hashed index, so predGshare diverges on the next lookup whose entries differ. The bench keeps a shadow of all three tables and the history, built from the requirements. It compares all three outputs after every step, so a fault is caught at the first lookup that can expose it.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  typedef struct packed {
    logic trainEn;
    logic outcome;
    logic chUp;
    logic chDown;
  } strobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cnt, input logic up);
    if (up) return (cnt == 2'd3) ? cnt : cnt + 2'd1;
    else    return (cnt == 2'd0) ? cnt : cnt - 2'd1;
  endfunction
endpackage

// File: rtl/tourn_ctrl.sv
module tourn_ctrl
  import tourn_pkg::*;
(
  input  logic    updValid,
  input  logic    updTaken,
  input  logic    updGsharePred,
  input  logic    updBimodalPred,
  output strobe_t strobe
);
  logic gsRight, bmRight;

  always_comb begin
    gsRight        = (updGsharePred == updTaken);
    bmRight        = (updBimodalPred == updTaken);
    strobe.trainEn = updValid;
    strobe.outcome = updTaken;
    strobe.chUp    = updValid & gsRight & ~bmRight;
    strobe.chDown  = updValid & bmRight & ~gsRight;
  end
endmodule

// File: rtl/tourn_datapath.sv
module tourn_datapath
  import tourn_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GS_IDX_W  = 6,
  parameter int BIM_IDX_W = 4,
  parameter int CH_IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ADDR_W-1:0] updPc,
  input  strobe_t           strobe,
  output logic              predTaken,
  output logic              predGshare,
  output logic              predBimodal
);
  localparam int GS_N  = 1 << GS_IDX_W;
  localparam int BIM_N = 1 << BIM_IDX_W;
  localparam int CH_N  = 1 << CH_IDX_W;

  logic [1:0] gsTab [GS_N];
  logic [1:0] bmTab [BIM_N];
  logic [1:0] chTab [CH_N];
  logic [GS_IDX_W-1:0] ghr;

  logic [GS_IDX_W-1:0]  gsLkIdx, gsUpIdx;
  logic [BIM_IDX_W-1:0] bmLkIdx, bmUpIdx;
  logic [CH_IDX_W-1:0]  chLkIdx, chUpIdx;

  always_comb begin
    gsLkIdx = ghr ^ lookupPc[GS_IDX_W-1:0];
    gsUpIdx = ghr ^ updPc[GS_IDX_W-1:0];
    bmLkIdx = lookupPc[BIM_IDX_W-1:0];
    bmUpIdx = updPc[BIM_IDX_W-1:0];
    chLkIdx = lookupPc[CH_IDX_W-1:0];
    chUpIdx = updPc[CH_IDX_W-1:0];
    predGshare  = gsTab[gsLkIdx][1];
    predBimodal = bmTab[bmLkIdx][1];
    predTaken   = chTab[chLkIdx][1] ? predGshare : predBimodal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GS_N; i++)  gsTab[i] <= 2'd1;
      for (int i = 0; i < BIM_N; i++) bmTab[i] <= 2'd1;
      for (int i = 0; i < CH_N; i++)  chTab[i] <= 2'd2;
      ghr <= '0;
    end else if (strobe.trainEn) begin
      gsTab[gsUpIdx] <= satStep(gsTab[gsUpIdx], strobe.outcome);
      bmTab[bmUpIdx] <= satStep(bmTab[bmUpIdx], strobe.outcome);
      if (strobe.chUp || strobe.chDown)
        chTab[chUpIdx] <= satStep(chTab[chUpIdx], strobe.chUp);
      ghr <= {ghr[GS_IDX_W-2:0], strobe.outcome};
    end
  end

  // Checking support: snapshot of the entries touched by an update
  logic [1:0] chAtUpd, bmAtUpd;
  logic [CH_IDX_W-1:0]  lastChIdx;
  logic [BIM_IDX_W-1:0] lastBmIdx;
  assign chAtUpd = chTab[chUpIdx];
  assign bmAtUpd = bmTab[bmUpIdx];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastChIdx <= '0;
      lastBmIdx <= '0;
    end else begin
      lastChIdx <= chUpIdx;
      lastBmIdx <= bmUpIdx;
    end
  end

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.trainEn |=> ghr == {$past(ghr[GS_IDX_W-2:0]), $past(strobe.outcome)});

  // R10
  idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.trainEn |=> $stable(ghr));

  // R7
  chooser_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.chUp |=> chTab[lastChIdx] == (($past(chAtUpd) == 2'd3) ? 2'd3 : $past(chAtUpd) + 2'd1));

  // R8
  chooser_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.chDown |=> chTab[lastChIdx] == (($past(chAtUpd) == 2'd0) ? 2'd0 : $past(chAtUpd) - 2'd1));

  // R9
  chooser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.trainEn && !strobe.chUp && !strobe.chDown) |=> chTab[lastChIdx] == $past(chAtUpd));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.chUp, strobe.chDown}));

  // R4
  bim_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.trainEn && strobe.outcome) |=> bmTab[lastBmIdx] >= $past(bmAtUpd));
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tourn_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GS_IDX_W  = 6,
  parameter int BIM_IDX_W = 4,
  parameter int CH_IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lookupPc,
  output logic              predTaken,
  output logic              predGshare,
  output logic              predBimodal,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic              updGsharePred,
  input  logic              updBimodalPred
);
  strobe_t strobe;

  tourn_ctrl u_ctrl (
    .updValid       (updValid),
    .updTaken       (updTaken),
    .updGsharePred  (updGsharePred),
    .updBimodalPred (updBimodalPred),
    .strobe         (strobe)
  );

  tourn_datapath #(
    .ADDR_W    (ADDR_W),
    .GS_IDX_W  (GS_IDX_W),
    .BIM_IDX_W (BIM_IDX_W),
    .CH_IDX_W  (CH_IDX_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookupPc    (lookupPc),
    .updPc       (updPc),
    .strobe      (strobe),
    .predTaken   (predTaken),
    .predGshare  (predGshare),
    .predBimodal (predBimodal)
  );
endmodule

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;
  localparam int AW = 16, GW = 6, BW = 4, CW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, predTaken, predGshare, predBimodal;
  logic updValid, updTaken, updGsharePred, updBimodalPred;
  logic [AW-1:0] lookupPc, updPc;

  tournament_predictor #(.ADDR_W(AW), .GS_IDX_W(GW), .BIM_IDX_W(BW), .CH_IDX_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predTaken),
    .predGshare(predGshare), .predBimodal(predBimodal), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updGsharePred(updGsharePred),
    .updBimodalPred(updBimodalPred));

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [1:0] mGs [1<<GW];
  logic [1:0] mBm [1<<BW];
  logic [1:0] mCh [1<<CW];
  logic [GW-1:0] mGhr;

  // stimulus: {taken, pc}
  localparam logic [AW:0] VEC [24] = '{
    17'h10021, 17'h10021, 17'h10021, 17'h00021,
    17'h10031, 17'h00031, 17'h10031, 17'h00031,
    17'h00007, 17'h00007, 17'h10017, 17'h10017,
    17'h10021, 17'h10021, 17'h10021, 17'h00021,
    17'h10031, 17'h00031, 17'h0002a, 17'h1002a,
    17'h0002a, 17'h1002a, 17'h10007, 17'h00007};

  function automatic logic [1:0] step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic modelReset();
    foreach (mGs[i]) mGs[i] = 2'd1;
    foreach (mBm[i]) mBm[i] = 2'd1;
    foreach (mCh[i]) mCh[i] = 2'd2;
    mGhr = '0;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareOuts(input logic [AW-1:0] pc, input string req);
    logic gE, bE, sE;
    gE = mGs[mGhr ^ pc[GW-1:0]][1];
    bE = mBm[pc[BW-1:0]][1];
    sE = mCh[pc[CW-1:0]][1] ? gE : bE;
    check(req, "predGshare", predGshare, gE);
    check(req, "predBimodal", predBimodal, bE);
    check(req, "predTaken", predTaken, sE);
  endtask

  task automatic probe(input logic [AW-1:0] pc, input string req);
    @(negedge clk);
    lookupPc = pc;
    #1;
    compareOuts(pc, req);
  endtask

  task automatic update(input logic [AW-1:0] pc, input logic tk, input logic gp, input logic bp);
    logic [GW-1:0] gi;
    @(negedge clk);
    updPc = pc; updTaken = tk; updGsharePred = gp; updBimodalPred = bp; updValid = 1'b1;
    lookupPc = pc;
    #1;
    compareOuts(pc, "R11");   // pending update not yet visible
    @(posedge clk);
    gi = mGhr ^ pc[GW-1:0];
    mGs[gi] = step(mGs[gi], tk);                 // R4
    mBm[pc[BW-1:0]] = step(mBm[pc[BW-1:0]], tk);
    if (gp == tk && bp != tk) mCh[pc[CW-1:0]] = step(mCh[pc[CW-1:0]], 1'b1);      // R7
    else if (bp == tk && gp != tk) mCh[pc[CW-1:0]] = step(mCh[pc[CW-1:0]], 1'b0); // R8
    mGhr = {mGhr[GW-2:0], tk};                   // R5
    #1 updValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    compared++; mismatched++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    finish();
  end

  initial begin
    rst_n = 1'b0; updValid = 1'b0; updTaken = 1'b0; updGsharePred = 1'b0;
    updBimodalPred = 1'b0; updPc = '0; lookupPc = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state at several addresses
    probe(16'h0000, "R1");
    probe(16'h0005, "R1");
    probe(16'h003f, "R1");

    // Table walk: R2 R3 R6 under mixed patterns, component preds as reported
    foreach (VEC[i]) begin
      logic [AW-1:0] pc;
      pc = VEC[i][AW-1:0];
      probe(pc, "R2/R3/R6");
      update(pc, VEC[i][AW], predGshare, predBimodal);
      probe(pc, "R4");
    end

    // R10: update inputs without the strobe change nothing
    @(negedge clk);
    updPc = 16'h0021; updTaken = 1'b0; updGsharePred = 1'b1; updBimodalPred = 1'b0;
    repeat (4) @(posedge clk);
    probe(16'h0021, "R10");
    probe(16'h0031, "R10");

    // R8: decrement and saturate at 0
    for (int k = 0; k < 4; k++) begin
      update(16'h0009, 1'b1, 1'b0, 1'b1);
      probe(16'h0009, "R8");
    end
    // R9: both right, then both wrong
    update(16'h0009, 1'b1, 1'b1, 1'b1);
    probe(16'h0009, "R9");
    update(16'h0009, 1'b0, 1'b1, 1'b1);
    probe(16'h0009, "R9");
    // R7: increment and saturate at 3
    for (int k = 0; k < 5; k++) begin
      update(16'h0009, 1'b0, 1'b0, 1'b1);
      probe(16'h0009, "R7");
    end
    // R6 via an aliasing address after the selector moved
    probe(16'h0019, "R6");
    probe(16'h0029, "R6");

    finish();
  end
endmodule